// File: doc/BRIEF.md
# Handshaked Parallel Input Port

This block sits between a processor bus and an external byte source. The source presents a byte and raises a valid line. The block captures the byte, answers with an accepted line and waits for valid to fall before it lowers accepted again, which completes a four-phase exchange. Every captured byte sets a ready flag in a status register. Software polls that flag and then reads the byte; that read clears the flag.

On the processor side a chip select and a two-bit register select pick one of four registers, which are accessed with separate read and write strobes. The bidirectional data bus is split into an input port, an output port and an output enable. When the block is not selected, the output enable stays low. A second byte that arrives while the flag is still set is held off: accepted stays low until software has read the byte already held, so no byte can be overwritten. The valid input passes through a two-flop synchronizer before the handshake logic sees it.

Top module: `hsk_input_port`

## Requirements
- R1: In the cycle after any cycle with `cpu_cs` low, `cpu_doe` is 0 and `cpu_dout` is 0, whatever `cpu_rs`, `cpu_rd` and `cpu_wr` are. A write strobe with `cpu_cs` low changes no register.
- R2: A read (`cpu_cs`=1, `cpu_rd`=1 for one cycle) puts the selected register on `cpu_dout` with `cpu_doe`=1 after the next rising edge. The `cpu_rs` codes are: 00 received byte, 01 port B register, 10 control register, 11 status register.
- R3: A write (`cpu_cs`=1, `cpu_wr`=1) with `cpu_rs`=01 loads `cpu_din` into the port B register, and one with `cpu_rs`=10 loads the control register. Writes with `cpu_rs`=00 or 11 change nothing a later read can see.
- R4: With the flag clear, `dev_ack` rises after the third rising edge at which `dev_valid` is high, and not before.
- R5: When `dev_ack` rises, the byte on `dev_data` is captured and the ready flag is set. Later changes of `dev_data` do not alter the captured byte.
- R6: `dev_ack` stays high while `dev_valid` stays high. It falls after the third rising edge at which `dev_valid` is low, and the block is then ready for the next byte.
- R7: The status register reads with bit 0 = ready flag, bit 1 = current `dev_ack` level, and all higher bits 0.
- R8: A read of register 00 clears the ready flag.
- R9: If `dev_valid` is high while the flag is set, `dev_ack` stays low and the held byte is kept until register 00 is read. The new byte is then accepted.
- R10: After reset, `dev_ack`, `cpu_doe`, the flag, the received byte, port B and control are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_data | input | DATA_W | Byte from the external source |
| dev_valid | input | 1 | Source indicates that `dev_data` is valid (asynchronous) |
| dev_ack | output | 1 | Block indicates that the byte was accepted |
| cpu_cs | input | 1 | Chip select |
| cpu_rs | input | 2 | Register select |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_din | input | DATA_W | Write data from the processor |
| cpu_dout | output | DATA_W | Read data to the processor |
| cpu_doe | output | 1 | Output enable for the processor data bus |

## Verification
Properties checked on every cycle:
- The output enable is released in the cycle after chip select drops.
- `dev_ack` rises only after the synchronized valid was high, and only while the flag was clear.
- `dev_ack` holds while valid holds, and falls once valid is gone.
- A capture sets the flag, a data read clears it, and a port B write takes the written value.

Only the bench scenarios show the following:
- The exact three-edge latency on both edges of the handshake.
- That the captured byte survives later changes of `dev_data`.
- That a held byte survives a blocked second transfer and is replaced after the read.
- Correct capture of all 256 byte values.
- That writes to the read-only registers leave nothing behind.

// File: rtl/hip_pkg.sv
package hip_pkg;
  typedef enum logic [1:0] {
    SEL_RXDATA = 2'b00,
    SEL_PORTB  = 2'b01,
    SEL_CTRL   = 2'b10,
    SEL_STATUS = 2'b11
  } hip_sel_e;

  typedef enum logic {
    HS_READY = 1'b0,
    HS_HOLD  = 1'b1
  } hip_hs_e;

  localparam int STAT_FLAG_BIT = 0;
  localparam int STAT_ACK_BIT  = 1;
endpackage

// File: rtl/hip_sync.sv
module hip_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hip_hs_fsm.sv
module hip_hs_fsm
  import hip_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic valid_s,
  input  logic flag,
  output logic ack,
  output logic take
);
  hip_hs_e state_q;

  // capture only when ready and the previous byte has been consumed
  assign take = (state_q == HS_READY) && valid_s && !flag;
  assign ack  = (state_q == HS_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= HS_READY;
    end else begin
      case (state_q)
        HS_READY: if (take)     state_q <= HS_HOLD;
        HS_HOLD:  if (!valid_s) state_q <= HS_READY;
        default:                state_q <= HS_READY;
      endcase
    end
  end

  // R4: accepted only rises after synchronized valid was seen high
  p_ack_after_valid_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(valid_s));
  // R9: accepted never rises while an unread byte is held
  p_no_overrun_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> !$past(flag));
  // R6: accepted holds while valid holds, and releases after valid falls
  p_ack_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (ack && valid_s) |=> ack);
  p_ack_release_r6: assert property (@(posedge clk) disable iff (rst)
    (ack && !valid_s) |=> !ack);
endmodule

// File: rtl/hip_regs.sv
module hip_regs
  import hip_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic [1:0]        rs,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] dev_data,
  input  logic              take,
  input  logic              ack,
  output logic [DATA_W-1:0] dout,
  output logic              doe,
  output logic              flag
);
  localparam int PAD_W = DATA_W - 2;

  logic [DATA_W-1:0] rx_q, portb_q, ctrl_q, dout_q, rd_mux, status_w;
  logic              flag_q, doe_q, acc_rd, acc_wr;

  assign acc_rd   = cs && rd;
  assign acc_wr   = cs && wr;
  assign status_w = {{PAD_W{1'b0}}, ack, flag_q};

  always_comb begin
    case (rs)
      SEL_RXDATA: rd_mux = rx_q;
      SEL_PORTB:  rd_mux = portb_q;
      SEL_CTRL:   rd_mux = ctrl_q;
      default:    rd_mux = status_w;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q    <= '0;
      portb_q <= '0;
      ctrl_q  <= '0;
      flag_q  <= 1'b0;
      dout_q  <= '0;
      doe_q   <= 1'b0;
    end else begin
      if (take) begin
        rx_q   <= dev_data;
        flag_q <= 1'b1;
      end else if (acc_rd && rs == SEL_RXDATA) begin
        flag_q <= 1'b0;
      end
      if (acc_wr && rs == SEL_PORTB) portb_q <= din;
      if (acc_wr && rs == SEL_CTRL)  ctrl_q  <= din;
      doe_q  <= acc_rd;
      dout_q <= acc_rd ? rd_mux : '0;
    end
  end

  assign dout = dout_q;
  assign doe  = doe_q;
  assign flag = flag_q;

  // R1: bus released after a deselected cycle
  p_hiz_deselect_r1: assert property (@(posedge clk) disable iff (rst)
    !cs |=> (!doe && dout == '0));
  // R5: a capture raises the ready flag
  p_flag_on_take_r5: assert property (@(posedge clk) disable iff (rst)
    take |=> flag);
  // R8: a data read clears the flag
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && rs == SEL_RXDATA && !take) |=> !flag);
  // R3: port B takes the written value
  p_portb_write_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && rs == SEL_PORTB) |=> portb_q == $past(din));
endmodule

// File: rtl/hsk_input_port.sv
module hsk_input_port
  import hip_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dev_data,
  input  logic              dev_valid,
  output logic              dev_ack,
  input  logic              cpu_cs,
  input  logic [1:0]        cpu_rs,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_din,
  output logic [DATA_W-1:0] cpu_dout,
  output logic              cpu_doe
);
  logic valid_s, take, flag, ack;

  hip_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(dev_valid), .q(valid_s)
  );

  hip_hs_fsm u_fsm (
    .clk(clk), .rst(rst), .valid_s(valid_s), .flag(flag),
    .ack(ack), .take(take)
  );

  hip_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .cs(cpu_cs), .rs(cpu_rs), .rd(cpu_rd),
    .wr(cpu_wr), .din(cpu_din), .dev_data(dev_data), .take(take),
    .ack(ack), .dout(cpu_dout), .doe(cpu_doe), .flag(flag)
  );

  assign dev_ack = ack;
endmodule

// File: tb/test_hsk_input_port.sv
module test_hsk_input_port;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic [DW-1:0] dev_data;
  logic          dev_valid;
  logic          dev_ack;
  logic          cpu_cs;
  logic [1:0]    cpu_rs;
  logic          cpu_rd, cpu_wr;
  logic [DW-1:0] cpu_din;
  logic [DW-1:0] cpu_dout;
  logic          cpu_doe;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  hsk_input_port i_hsk_input_port (
    .clk(clk), .rst(rst), .dev_data(dev_data), .dev_valid(dev_valid),
    .dev_ack(dev_ack), .cpu_cs(cpu_cs), .cpu_rs(cpu_rs), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_din(cpu_din), .cpu_dout(cpu_dout), .cpu_doe(cpu_doe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [DW-1:0] v, output logic en);
    @(negedge clk); cpu_cs = 1'b1; cpu_rd = 1'b1; cpu_rs = sel;
    @(negedge clk); cpu_cs = 1'b0; cpu_rd = 1'b0;
    v = cpu_dout; en = cpu_doe;
  endtask

  task automatic expect_reg(input logic [1:0] sel, input int exp, input string req);
    logic [DW-1:0] v;
    logic en;
    rd_reg(sel, v, en);
    chk(en == 1'b1 && int'(v) == exp, req, int'(v), exp);
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [DW-1:0] val);
    @(negedge clk); cpu_cs = 1'b1; cpu_wr = 1'b1; cpu_rs = sel; cpu_din = val;
    @(negedge clk); cpu_cs = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic wait_ack(input logic lvl, output int n);
    n = 0;
    while (dev_ack !== lvl && n < 50) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic send_byte(input logic [DW-1:0] b);
    int n;
    @(negedge clk); dev_data = b; dev_valid = 1'b1;
    wait_ack(1'b1, n);
    chk(n <= 4, "R4 ack within handshake", n, 3);
    dev_data = ~b;  // source changes data after accept: R5 capture must hold
    @(negedge clk); dev_valid = 1'b0;
    wait_ack(1'b0, n);
    chk(n <= 4, "R6 ack release", n, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    rst = 1'b1; dev_data = '0; dev_valid = 1'b0;
    cpu_cs = 1'b0; cpu_rs = 2'b00; cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_din = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state; R2 read path for every register
    chk(dev_ack == 1'b0, "R10 ack after reset", int'(dev_ack), 0);
    chk(cpu_doe == 1'b0, "R10 doe after reset", int'(cpu_doe), 0);
    expect_reg(2'b11, 0, "R10 status after reset");
    expect_reg(2'b01, 0, "R10 port B after reset");
    expect_reg(2'b10, 0, "R10 control after reset");
    expect_reg(2'b00, 0, "R10 rx after reset");

    // R1 deselected cycles, every select code, read and write strobes
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 2; w++) begin
        @(negedge clk);
        cpu_cs = 1'b0; cpu_rd = 1'b1; cpu_wr = w[0]; cpu_rs = s[1:0]; cpu_din = 8'hFF;
        @(negedge clk);
        chk(cpu_doe == 1'b0 && cpu_dout == '0, "R1 deselect releases bus",
            int'(cpu_doe), 0);
      end
    end
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    expect_reg(2'b01, 0, "R1 deselected write ignored port B");
    expect_reg(2'b10, 0, "R1 deselected write ignored control");

    // R3 writes and read-only registers
    wr_reg(2'b01, 8'h5A);
    wr_reg(2'b10, 8'hC3);
    wr_reg(2'b00, 8'h77);
    wr_reg(2'b11, 8'hFF);
    expect_reg(2'b01, 8'h5A, "R3 port B write");
    expect_reg(2'b10, 8'hC3, "R3 control write");
    expect_reg(2'b11, 0, "R3 status write ignored");
    expect_reg(2'b00, 0, "R3 rx write ignored");

    // R4 exact latency of accept
    @(negedge clk); dev_data = 8'hA5; dev_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(dev_ack == 1'b0, "R4 no ack after two edges", int'(dev_ack), 0);
    @(negedge clk);
    chk(dev_ack == 1'b1, "R4 ack after third edge", int'(dev_ack), 1);
    dev_data = 8'h00;
    expect_reg(2'b11, 3, "R7 status flag and ack high");
    chk(dev_ack == 1'b1, "R6 ack held while valid high", int'(dev_ack), 1);
    // R6 exact latency of release
    @(negedge clk); dev_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(dev_ack == 1'b1, "R6 ack held two edges after valid low", int'(dev_ack), 1);
    @(negedge clk);
    chk(dev_ack == 1'b0, "R6 ack low after third edge", int'(dev_ack), 0);
    expect_reg(2'b11, 1, "R7 status flag only");
    expect_reg(2'b00, 8'hA5, "R5 captured byte");
    expect_reg(2'b11, 0, "R8 flag cleared by data read");

    // R9 overrun protection
    send_byte(8'h3C);
    @(negedge clk); dev_data = 8'hC6; dev_valid = 1'b1;
    repeat (12) @(negedge clk);
    chk(dev_ack == 1'b0, "R9 ack withheld while flag set", int'(dev_ack), 0);
    expect_reg(2'b11, 1, "R9 status during hold-off");
    expect_reg(2'b00, 8'h3C, "R9 held byte kept");
    wait_ack(1'b1, n);
    chk(n <= 4, "R9 accept after read", n, 2);
    expect_reg(2'b11, 3, "R9 R7 status after late accept");
    @(negedge clk); dev_valid = 1'b0;
    wait_ack(1'b0, n);
    expect_reg(2'b00, 8'hC6, "R9 second byte");
    expect_reg(2'b11, 0, "R8 flag cleared after second byte");

    // R5 sweep of every byte value
    for (int v = 0; v < 256; v++) begin
      send_byte(v[DW-1:0]);
      expect_reg(2'b11, 1, "R5 flag set in sweep");
      expect_reg(2'b00, v, "R5 sweep byte");
      expect_reg(2'b11, 0, "R8 flag clear in sweep");
    end
    expect_reg(2'b01, 8'h5A, "R3 port B undisturbed");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule